// File: doc/BRIEF.md
# Serial Audio Receiver with Zero Detect

The block takes a three-wire serial audio stream made of a bit clock, a word clock and a data line. It turns the stream into parallel stereo samples. All three stream lines are sampled in the block's own clock domain. A rising edge of the bit clock is found by comparing the bit clock with its value one system clock earlier. The word clock toggles once per channel slot, and the bit clock runs at 32, 48 or 64 times the frame rate, which gives slots of 16, 24 or 32 bits.

Two framings are supported:
- **Right-justified:** the last bit of each channel word sits just before the word-clock transition. A polarity input chooses which word-clock level marks the left channel.
- **I2S:** the first bit of each channel word follows the transition by one bit clock, and left is always the low half.

Words of 16, 20 or 24 bits arrive two's complement, MSB first. Each word is sign-extended to 24 bits. The left and right samples of a frame are presented together with a one-cycle valid strobe.

An infinite-zero detector counts consecutive bit-clock rising edges that carry a zero on the data line. After a long run it drives an active-low flag. The flag can gate an external mute.

Top module: `serAudioRx`

## Requirements
- R1: After reset, leftSample and rightSample are 0, sampleValid is 0 and zeroFlagN is 1.
- R2: With fmtI2s = 0 and lrPol = 0, the word sent while wordClk is high is the left word. The word sent while wordClk is low is the right word. The LSB of each word is the bit captured on the last bit-clock rising edge before the wordClk transition.
- R3: With fmtI2s = 0 and lrPol = 1, the word sent while wordClk is low is the left word and the word sent while wordClk is high is the right word.
- R4: With fmtI2s = 1, the MSB is captured on the second bit-clock rising edge of a slot, and the slot with wordClk low is the left channel. lrPol has no effect on the result.
- R5: wordSel selects the word length: 00 gives 16 bits, 01 gives 20 bits and 10 gives 24 bits. The code 11 is treated as 16 bits.
- R6: Each received word is sign-extended from its MSB to 24 bits on leftSample and rightSample.
- R7: sampleValid goes high for exactly one clock cycle. That cycle follows the clock edge that detects the bit-clock rising edge completing the right word. leftSample and rightSample change only in that cycle and hold their values otherwise.
- R8: zeroFlagN goes low once ZERO_RUN consecutive bit-clock rising edges have seen serData = 0. The default ZERO_RUN is 65536. After ZERO_RUN - 1 such edges, zeroFlagN is still high.
- R9: A bit-clock rising edge that sees serData = 1 restarts the zero run, and zeroFlagN is high in the next clock cycle.
- R10: Slot lengths of 16, 24 and 32 bit clocks are handled. This includes I2S with 16-bit words in 16-bit slots, where the LSB of each word falls on the first edge of the following slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every stream line is sampled on its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| bitClk | input | 1 | Serial bit clock |
| wordClk | input | 1 | Left/right word clock, toggling once per channel slot |
| serData | input | 1 | Serial audio data, MSB first |
| fmtI2s | input | 1 | Framing select: 0 right-justified, 1 I2S |
| wordSel | input | 2 | Word length code: 00 = 16, 01 = 20, 10 = 24, 11 = 16 |
| lrPol | input | 1 | Right-justified polarity: 0 = left while wordClk is high, 1 = left while wordClk is low |
| leftSample | output | 24 | Sign-extended left sample |
| rightSample | output | 24 | Sign-extended right sample |
| sampleValid | output | 1 | One-cycle strobe when a new stereo pair is presented |
| zeroFlagN | output | 1 | Active-low flag for a long run of zero data |

## Verification
The hardest case to reach is I2S in 16-bit slots with 16-bit words. There the LSB of a word is only taken on the very edge that also starts the next slot, so the capture and the slot change coincide. The stimulus builds that case by putting each previous word's LSB into position zero of the next slot, with a trailing slot after the last right word.

The zero run is instantiated with a short ZERO_RUN. The stimulus then sends exactly one edge fewer than the limit, then the limit, and then a single one bit. This confirms the exact threshold and the next-cycle release.

// File: rtl/serAudioPkg.sv
package serAudioPkg;

  // Widest word and output sample width
  localparam int MAX_WORD = 24;
  // Width of the bit counter inside a slot (slots up to 32 bits, saturating)
  localparam int SLOT_CNT_W = 6;
  // Width of a word-length value
  localparam int LEN_W = $clog2(MAX_WORD + 1);

  // Strobes from control to datapath
  typedef struct packed {
    logic bitRise;      // bit-clock rising edge seen this cycle
    logic capLeft;      // take the current word as left
    logic capRight;     // take the current word as right and present the pair
    logic useIncoming;  // word ends with the bit arriving now
  } rxStrobes_t;

  function automatic logic [LEN_W-1:0] wordLenOf(input logic [1:0] sel);
    logic [LEN_W-1:0] len;
    case (sel)
      2'b01:   len = LEN_W'(20);
      2'b10:   len = LEN_W'(24);
      default: len = LEN_W'(16);
    endcase
    return len;
  endfunction

endpackage

// File: rtl/serAudioCtrl.sv
module serAudioCtrl
  import serAudioPkg::*;
#(
  parameter int CNT_W = SLOT_CNT_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitClk,
  input  logic             wordClk,
  input  logic             fmtI2s,
  input  logic             lrPol,
  input  logic [LEN_W-1:0] wordLen,
  output rxStrobes_t       strobes
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             bitClkQ;
  logic             wordPrev;
  logic             primed;
  logic             synced;
  logic [CNT_W-1:0] slotCnt;

  logic bitRise;
  logic wordEdge;
  logic slotIsLeft;
  logic rjTake;
  logic i2sTake;
  logic take;

  assign bitRise  = bitClk & ~bitClkQ;
  assign wordEdge = bitRise & primed & (wordClk != wordPrev);

  // Channel of the slot in progress, taken from the level before any edge
  always_comb begin
    if (fmtI2s)     slotIsLeft = ~wordPrev;
    else if (lrPol) slotIsLeft = ~wordPrev;
    else            slotIsLeft = wordPrev;
  end

  // Right-justified: a word completes at the slot boundary.
  // I2S: a word completes when the incoming bit is at slot position wordLen.
  assign rjTake  = ~fmtI2s & synced & wordEdge;
  assign i2sTake = fmtI2s & synced & bitRise &
                   ((slotCnt + CNT_W'(1)) == CNT_W'(wordLen));
  assign take    = rjTake | i2sTake;

  always_comb begin
    strobes.bitRise     = bitRise;
    strobes.capLeft     = take & slotIsLeft;
    strobes.capRight    = take & ~slotIsLeft;
    strobes.useIncoming = fmtI2s;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitClkQ  <= 1'b0;
      wordPrev <= 1'b0;
      primed   <= 1'b0;
      synced   <= 1'b0;
      slotCnt  <= '0;
    end else begin
      bitClkQ <= bitClk;
      if (bitRise) begin
        wordPrev <= wordClk;
        primed   <= 1'b1;
        if (wordEdge) begin
          synced  <= 1'b1;
          slotCnt <= '0;
        end else if (slotCnt != CNT_MAX) begin
          slotCnt <= slotCnt + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/serAudioData.sv
module serAudioData
  import serAudioPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                serData,
  input  rxStrobes_t          strobes,
  input  logic [LEN_W-1:0]    wordLen,
  output logic [MAX_WORD-1:0] leftSample,
  output logic [MAX_WORD-1:0] rightSample,
  output logic                sampleValid
);

  logic [MAX_WORD-1:0]        shiftReg;
  logic [MAX_WORD-1:0]        window;
  logic [MAX_WORD-1:0]        leftHold;
  logic [LEN_W-1:0]           padBits;
  logic signed [MAX_WORD-1:0] extended;

  // Most recent bits, optionally including the one arriving this cycle
  assign window   = strobes.useIncoming ? {shiftReg[MAX_WORD-2:0], serData} : shiftReg;
  assign padBits  = LEN_W'(MAX_WORD) - wordLen;
  assign extended = $signed(window << padBits) >>> padBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg    <= '0;
      leftHold    <= '0;
      leftSample  <= '0;
      rightSample <= '0;
      sampleValid <= 1'b0;
    end else begin
      if (strobes.bitRise) shiftReg <= {shiftReg[MAX_WORD-2:0], serData};
      if (strobes.capLeft) leftHold <= extended;
      sampleValid <= strobes.capRight;
      if (strobes.capRight) begin
        leftSample  <= leftHold;
        rightSample <= extended;
      end
    end
  end

endmodule

// File: rtl/serAudioZero.sv
module serAudioZero #(
  parameter int RUN_LEN = 65536
) (
  input  logic clk,
  input  logic rstN,
  input  logic serData,
  input  logic bitRise,
  output logic zeroFlagN
);

  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] RUN_TOP = CW'(RUN_LEN);

  logic [CW-1:0] zeroCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      zeroCnt <= '0;
    end else if (bitRise) begin
      if (serData)                zeroCnt <= '0;
      else if (zeroCnt != RUN_TOP) zeroCnt <= zeroCnt + CW'(1);
    end
  end

  assign zeroFlagN = (zeroCnt != RUN_TOP);

endmodule

// File: rtl/serAudioRx.sv
module serAudioRx
  import serAudioPkg::*;
#(
  parameter int ZERO_RUN = 65536
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bitClk,
  input  logic                wordClk,
  input  logic                serData,
  input  logic                fmtI2s,
  input  logic [1:0]          wordSel,
  input  logic                lrPol,
  output logic [MAX_WORD-1:0] leftSample,
  output logic [MAX_WORD-1:0] rightSample,
  output logic                sampleValid,
  output logic                zeroFlagN
);

  rxStrobes_t       strobes;
  logic [LEN_W-1:0] wordLen;

  assign wordLen = wordLenOf(wordSel);

  serAudioCtrl #(.CNT_W(SLOT_CNT_W)) ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .bitClk  (bitClk),
    .wordClk (wordClk),
    .fmtI2s  (fmtI2s),
    .lrPol   (lrPol),
    .wordLen (wordLen),
    .strobes (strobes)
  );

  serAudioData data (
    .clk         (clk),
    .rstN        (rstN),
    .serData     (serData),
    .strobes     (strobes),
    .wordLen     (wordLen),
    .leftSample  (leftSample),
    .rightSample (rightSample),
    .sampleValid (sampleValid)
  );

  serAudioZero #(.RUN_LEN(ZERO_RUN)) zero (
    .clk       (clk),
    .rstN      (rstN),
    .serData   (serData),
    .bitRise   (strobes.bitRise),
    .zeroFlagN (zeroFlagN)
  );

endmodule

// File: rtl/serAudioRxChk.sv
module serAudioRxChk
  import serAudioPkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                serData,
  input logic                sampleValid,
  input logic                zeroFlagN,
  input logic [MAX_WORD-1:0] leftSample,
  input logic [MAX_WORD-1:0] rightSample,
  input rxStrobes_t          strobes
);

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid); // R7

  AST_LEFT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(leftSample) |-> sampleValid); // R7

  AST_RIGHT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rightSample) |-> sampleValid); // R7

  AST_ZERO_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.bitRise && serData) |=> zeroFlagN); // R9

  AST_ZERO_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (!zeroFlagN && !(strobes.bitRise && serData)) |=> !zeroFlagN); // R8

  AST_CAPTURE_ON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capLeft || strobes.capRight) |-> strobes.bitRise); // R2

endmodule

bind serAudioRx serAudioRxChk chk (
  .clk         (clk),
  .rstN        (rstN),
  .serData     (serData),
  .sampleValid (sampleValid),
  .zeroFlagN   (zeroFlagN),
  .leftSample  (leftSample),
  .rightSample (rightSample),
  .strobes     (strobes)
);

// File: tb/serAudioRx_test.sv
`timescale 1ns/1ps
module serAudioRx_test;

  localparam int TB_RUN = 300;
  localparam int WATCHDOG_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitClk = 1'b0;
  logic        wordClk = 1'b0;
  logic        serData = 1'b0;
  logic        fmtI2s = 1'b0;
  logic [1:0]  wordSel = 2'b00;
  logic        lrPol = 1'b0;
  logic [23:0] leftSample;
  logic [23:0] rightSample;
  logic        sampleValid;
  logic        zeroFlagN;

  int checks = 0;
  int fails = 0;
  int validCnt = 0;
  logic [23:0] gotL = '0;
  logic [23:0] gotR = '0;
  bit finished = 0;

  serAudioRx #(.ZERO_RUN(TB_RUN)) uut (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .wordClk(wordClk), .serData(serData),
    .fmtI2s(fmtI2s), .wordSel(wordSel), .lrPol(lrPol),
    .leftSample(leftSample), .rightSample(rightSample),
    .sampleValid(sampleValid), .zeroFlagN(zeroFlagN)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (rstN && sampleValid) begin
      validCnt = validCnt + 1;
      gotL = leftSample;
      gotR = rightSample;
    end
  end

  task automatic check(input string req, input string what, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] sx(input logic [23:0] v, input int w);
    logic signed [23:0] t;
    t = v << (24 - w);
    return 24'(t >>> (24 - w));
  endfunction

  task automatic doReset(input logic i2s, input logic [1:0] sel, input logic pol);
    @(negedge clk);
    rstN = 1'b0; fmtI2s = i2s; wordSel = sel; lrPol = pol;
    bitClk = 1'b0; wordClk = 1'b0; serData = 1'b0;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    validCnt = 0;
  endtask

  task automatic sendBit(input logic b, input logic lvl);
    @(negedge clk);
    bitClk = 1'b0; wordClk = lvl; serData = b;
    @(negedge clk);
    bitClk = 1'b1;
  endtask

  task automatic sendSlot(input logic lvl, input logic i2s, input int w, input int len,
                          input logic [23:0] val, input logic prevLsb);
    for (int i = 0; i < len; i++) begin
      logic b;
      b = 1'b0;
      if (!i2s) begin
        if (i >= len - w) b = val[len - 1 - i];
      end else begin
        if (i == 0 && len == w) b = prevLsb;
        else if (i >= 1 && i <= w) b = val[w - i];
      end
      sendBit(b, lvl);
    end
  endtask

  task automatic runFrames(input logic i2s, input logic pol, input int w, input int len,
                           input logic [23:0] l0, input logic [23:0] r0,
                           input bit two, input logic [23:0] l1, input logic [23:0] r1);
    logic lvlL;
    lvlL = i2s ? 1'b0 : (pol ? 1'b0 : 1'b1);
    sendSlot(~lvlL, i2s, w, len, 24'h0, 1'b0);
    sendSlot(lvlL, i2s, w, len, l0, 1'b0);
    sendSlot(~lvlL, i2s, w, len, r0, l0[0]);
    if (two) begin
      sendSlot(lvlL, i2s, w, len, l1, r0[0]);
      sendSlot(~lvlL, i2s, w, len, r1, l1[0]);
      sendSlot(lvlL, i2s, w, len, 24'h0, r1[0]);
    end else begin
      sendSlot(lvlL, i2s, w, len, 24'h0, r0[0]);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic testReset;
    doReset(1'b0, 2'b00, 1'b0);
    @(negedge clk);
    check("R1", "leftSample", leftSample, 24'h0);
    check("R1", "rightSample", rightSample, 24'h0);
    check("R1", "sampleValid", {23'h0, sampleValid}, 24'h0);
    check("R1", "zeroFlagN", {23'h0, zeroFlagN}, 24'h1);
  endtask

  task automatic testFrame(input string req, input logic i2s, input logic [1:0] sel, input logic pol,
                           input int w, input int len, input logic [23:0] l, input logic [23:0] r);
    doReset(i2s, sel, pol);
    runFrames(i2s, pol, w, len, l, r, 1'b0, 24'h0, 24'h0);
    check(req, "valid count", 24'(validCnt), 24'd1);
    check(req, "left", gotL, sx(l, w));
    check(req, "right", gotR, sx(r, w));
  endtask

  task automatic testTwoFrames;
    doReset(1'b0, 2'b10, 1'b0);
    runFrames(1'b0, 1'b0, 24, 32, 24'h111111, 24'h222222, 1'b1, 24'hF00000, 24'h0F0F0F);
    check("R7", "valid count two frames", 24'(validCnt), 24'd2);
    check("R7", "second left", gotL, 24'hF00000);
    check("R7", "second right", gotR, 24'h0F0F0F);
    repeat (10) @(negedge clk);
    check("R7", "left holds", leftSample, 24'hF00000);
    check("R7", "right holds", rightSample, 24'h0F0F0F);
  endtask

  task automatic testZero;
    doReset(1'b0, 2'b00, 1'b0);
    for (int i = 0; i < TB_RUN - 1; i++) sendBit(1'b0, 1'b0);
    @(negedge clk);
    check("R8", "flag one edge short", {23'h0, zeroFlagN}, 24'h1);
    sendBit(1'b0, 1'b0);
    @(negedge clk);
    check("R8", "flag at run length", {23'h0, zeroFlagN}, 24'h0);
    sendBit(1'b0, 1'b1);
    @(negedge clk);
    check("R8", "flag stays low", {23'h0, zeroFlagN}, 24'h0);
    sendBit(1'b1, 1'b1);
    @(negedge clk);
    check("R9", "flag released by one", {23'h0, zeroFlagN}, 24'h1);
    for (int i = 0; i < TB_RUN - 1; i++) sendBit(1'b0, 1'b1);
    @(negedge clk);
    check("R9", "run restarted", {23'h0, zeroFlagN}, 24'h1);
  endtask

  initial begin
    testReset();
    testFrame("R2 R6 R10", 1'b0, 2'b00, 1'b0, 16, 16, 24'h008001, 24'h007FFE);
    testFrame("R3 R5", 1'b0, 2'b01, 1'b1, 20, 24, 24'h07ABCD, 24'h0F0123);
    testFrame("R4 R5", 1'b1, 2'b10, 1'b1, 24, 32, 24'h800000, 24'h123456);
    testFrame("R4 R10", 1'b1, 2'b00, 1'b0, 16, 16, 24'h00C3A5, 24'h000001);
    testFrame("R5 R6", 1'b0, 2'b11, 1'b0, 16, 32, 24'h0000FF, 24'h00FFFF);
    testTwoFrames();
    testZero();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1..: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule